// File: doc/BRIEF.md
# Load/Store Queue Occupancy Tracker

This block keeps the bookkeeping for the in-flight memory instructions of one thread. It manages two circular queues, one for loads and one for stores. Each entry holds the instruction's sequence number and, for stores, a set of status flags. Addresses, data and forwarding live elsewhere. The tracker only decides which slots are occupied, which stores may go to memory, and which entries leave on commit, on write completion or on a squash.

Loads leave the queue when they commit. A store is marked committed when the commit stage says so. A writeback pointer then offers the committed store to memory through a ready/accept handshake. The store's slot is freed only after that write has been accepted. A squash removes the youngest entries one per cycle until every remaining entry is no younger than the squash point. Each queue has one spare slot, so its usable capacity is its slot count minus one.

Top module: `lsq_tracker`

## Requirements
- R1: After reset both queues are empty. Both counts and the pending-writeback count are zero, each free count equals its slot count minus one, `squash_busy` is 0 and `st_wb_valid` is 0.
- R2: A load allocation writes the load at the load tail and raises `lq_count` by one on the next edge. `lq_full` is 1 when `lq_count` equals LQ_SLOTS-1, and an allocation made while full is ignored.
- R3: A store allocation behaves in the same way against SQ_SLOTS-1. `sq_full` rises at that count, and further store allocations are ignored.
- R4: `ld_alloc_idx` and `st_alloc_idx` report the slot the next allocation will use. These indices advance by one modulo the slot count and wrap from slot count minus one to 0.
- R5: Sequence numbers are compared unsigned, and a larger number is younger. While `cm_ld_valid` is 1, one head load per cycle is released if its sequence number is not greater than `cm_ld_seq`. Release stops at the first younger load.
- R6: In a cycle with `cm_st_valid` = 1, every occupied store whose sequence number is not greater than `cm_st_seq` becomes committed and eligible for writeback. `wb_pending` counts the stores that are eligible but not yet written.
- R7: `st_wb_valid` is 1 exactly when the store at the writeback pointer is occupied, eligible and not yet written. It then presents that store's index in `st_wb_idx`, and the size and all-zero flag last written by `st_exec` to that index.
- R8: A store is accepted in a cycle where `st_wb_valid` and `mem_ready` are both 1. It is marked written and the writeback pointer advances by one modulo SQ_SLOTS. While `mem_ready` is 0, the same store stays offered.
- R9: A store's slot is freed one cycle after its write has been accepted, once it is at the head. A commit alone does not change `sq_count`.
- R10: A `sq_req` pulse given while `squash_busy` is 0 latches `sq_seq`, and `squash_busy` rises on the next edge. In each busy cycle, each queue drops its youngest entry if that entry is younger than the latched number. `squash_busy` falls after a cycle in which neither queue drops an entry. Allocations and load commits are ignored while busy.
- R11: A squash never removes a committed store, and the store tail never retreats past the writeback pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_alloc | input | 1 | Allocate a load |
| ld_seq | input | SEQ_W | Sequence number of the allocated load |
| st_alloc | input | 1 | Allocate a store |
| st_seq | input | SEQ_W | Sequence number of the allocated store |
| st_exec | input | 1 | Record size and zero flag of an executed store |
| st_exec_idx | input | SIW | Store slot being recorded |
| st_exec_size | input | SIZE_W | Access size in bytes |
| st_exec_zero | input | 1 | Store writes an all-zero block |
| cm_ld_valid | input | 1 | Load commit request |
| cm_ld_seq | input | SEQ_W | Youngest committed sequence number for loads |
| cm_st_valid | input | 1 | Store commit request |
| cm_st_seq | input | SEQ_W | Youngest committed sequence number for stores |
| sq_req | input | 1 | Squash request pulse |
| sq_seq | input | SEQ_W | Squash point; younger entries are removed |
| mem_ready | input | 1 | Memory accepts the offered store |
| ld_alloc_idx | output | LIW | Slot for the next load |
| st_alloc_idx | output | SIW | Slot for the next store |
| lq_count | output | LCW | Loads held |
| sq_count | output | SCW | Stores held |
| lq_free | output | LCW | Free load slots |
| sq_free | output | SCW | Free store slots |
| lq_full | output | 1 | Load queue at capacity |
| sq_full | output | 1 | Store queue at capacity |
| lq_empty | output | 1 | No loads held |
| sq_empty | output | 1 | No stores held |
| wb_pending | output | SCW | Stores eligible but not yet written |
| squash_busy | output | 1 | Squash walk in progress |
| st_wb_valid | output | 1 | A store is offered to memory |
| st_wb_idx | output | SIW | Slot of the offered store |
| st_wb_size | output | SIZE_W | Size of the offered store |
| st_wb_zero | output | 1 | Offered store is an all-zero block |

## Verification
The bench runs with 6 load slots and 5 store slots, so every pointer has to wrap at a count that is not a power of two. A design that wrapped on the bit width would report a slot index past the end. The bench fills both queues past capacity; a tracker without the spare slot would accept one entry too many. It commits loads up to a boundary in the middle of the queue, where an off-by-one compare would release one load too many or too few. It holds memory not-ready to catch a writeback pointer that slips, and it checks that the store count falls only after acceptance, which a design that frees stores at commit would fail. Finally it squashes across a committed store and while allocations are attempted. A tail that ran past the writeback pointer, or an allocation that slipped in during the walk, would leave the wrong counts.

// File: rtl/lsq_tracker.sv
module lsq_tracker #(
  parameter int LQ_SLOTS = 8,
  parameter int SQ_SLOTS = 8,
  parameter int SEQ_W    = 16,
  parameter int SIZE_W   = 5,
  localparam int LIW = $clog2(LQ_SLOTS),
  localparam int SIW = $clog2(SQ_SLOTS),
  localparam int LCW = $clog2(LQ_SLOTS + 1),
  localparam int SCW = $clog2(SQ_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_alloc,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic              st_alloc,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic              st_exec,
  input  logic [SIW-1:0]    st_exec_idx,
  input  logic [SIZE_W-1:0] st_exec_size,
  input  logic              st_exec_zero,
  input  logic              cm_ld_valid,
  input  logic [SEQ_W-1:0]  cm_ld_seq,
  input  logic              cm_st_valid,
  input  logic [SEQ_W-1:0]  cm_st_seq,
  input  logic              sq_req,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              mem_ready,
  output logic [LIW-1:0]    ld_alloc_idx,
  output logic [SIW-1:0]    st_alloc_idx,
  output logic [LCW-1:0]    lq_count,
  output logic [SCW-1:0]    sq_count,
  output logic [LCW-1:0]    lq_free,
  output logic [SCW-1:0]    sq_free,
  output logic              lq_full,
  output logic              sq_full,
  output logic              lq_empty,
  output logic              sq_empty,
  output logic [SCW-1:0]    wb_pending,
  output logic              squash_busy,
  output logic              st_wb_valid,
  output logic [SIW-1:0]    st_wb_idx,
  output logic [SIZE_W-1:0] st_wb_size,
  output logic              st_wb_zero
);

  function automatic logic [LIW-1:0] l_inc(input logic [LIW-1:0] p);
    return (p == LIW'(LQ_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [LIW-1:0] l_dec(input logic [LIW-1:0] p);
    return (p == '0) ? LIW'(LQ_SLOTS - 1) : p - 1'b1;
  endfunction
  function automatic logic [SIW-1:0] s_inc(input logic [SIW-1:0] p);
    return (p == SIW'(SQ_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [SIW-1:0] s_dec(input logic [SIW-1:0] p);
    return (p == '0) ? SIW'(SQ_SLOTS - 1) : p - 1'b1;
  endfunction

  logic [SEQ_W-1:0]  lq_seq [LQ_SLOTS];
  logic [LIW-1:0]    lq_head, lq_tail;
  logic [LCW-1:0]    lq_cnt;

  logic [SEQ_W-1:0]  sq_sn   [SQ_SLOTS];
  logic [SIZE_W-1:0] sq_size [SQ_SLOTS];
  logic [SQ_SLOTS-1:0] sq_vld, sq_canwb, sq_cmt, sq_done, sq_zero;
  logic [SIW-1:0]    sq_head, sq_wb, sq_tail;
  logic [SCW-1:0]    sq_cnt;

  logic              busy;
  logic [SEQ_W-1:0]  tgt;

  logic [LIW-1:0] lq_last;
  logic [SIW-1:0] st_last;
  logic ld_go, ld_pop, ld_kill, st_go, st_ret, st_kill, wb_fire;

  assign lq_last = l_dec(lq_tail);
  assign st_last = s_dec(sq_tail);

  assign lq_full  = lq_cnt >= LCW'(LQ_SLOTS - 1);
  assign sq_full  = sq_cnt >= SCW'(SQ_SLOTS - 1);
  assign lq_empty = lq_cnt == '0;
  assign sq_empty = sq_cnt == '0;
  assign lq_free  = LCW'(LQ_SLOTS - 1) - lq_cnt;
  assign sq_free  = SCW'(SQ_SLOTS - 1) - sq_cnt;
  assign lq_count = lq_cnt;
  assign sq_count = sq_cnt;
  assign ld_alloc_idx = lq_tail;
  assign st_alloc_idx = sq_tail;
  assign squash_busy  = busy;

  assign ld_go   = ld_alloc && !lq_full && !busy;
  assign ld_pop  = cm_ld_valid && !busy && !lq_empty && (lq_seq[lq_head] <= cm_ld_seq);
  assign ld_kill = busy && !lq_empty && (lq_seq[lq_last] > tgt);

  assign st_go   = st_alloc && !sq_full && !busy;
  assign st_ret  = sq_vld[sq_head] && sq_done[sq_head];
  assign st_kill = busy && !sq_empty && (sq_tail != sq_wb) && !sq_cmt[st_last]
                   && (sq_sn[st_last] > tgt);

  assign st_wb_valid = sq_vld[sq_wb] && sq_canwb[sq_wb] && !sq_done[sq_wb];
  assign st_wb_idx   = sq_wb;
  assign st_wb_size  = sq_size[sq_wb];
  assign st_wb_zero  = sq_zero[sq_wb];
  assign wb_fire     = st_wb_valid && mem_ready;

  always_comb begin
    wb_pending = '0;
    for (int i = 0; i < SQ_SLOTS; i++)
      wb_pending = wb_pending + SCW'(sq_canwb[i] & ~sq_done[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lq_head <= '0;
      lq_tail <= '0;
      lq_cnt  <= '0;
      for (int i = 0; i < LQ_SLOTS; i++) lq_seq[i] <= '0;
    end else begin
      if (ld_go) begin
        lq_seq[lq_tail] <= ld_seq;
        lq_tail <= l_inc(lq_tail);
      end else if (ld_kill) begin
        lq_tail <= lq_last;
      end
      if (ld_pop) lq_head <= l_inc(lq_head);
      lq_cnt <= lq_cnt + LCW'(ld_go) - LCW'(ld_pop) - LCW'(ld_kill);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_head  <= '0;
      sq_wb    <= '0;
      sq_tail  <= '0;
      sq_cnt   <= '0;
      sq_vld   <= '0;
      sq_canwb <= '0;
      sq_cmt   <= '0;
      sq_done  <= '0;
      sq_zero  <= '0;
      for (int i = 0; i < SQ_SLOTS; i++) begin
        sq_sn[i]   <= '0;
        sq_size[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SQ_SLOTS; i++) begin
        if (st_exec && st_exec_idx == SIW'(i)) begin
          sq_size[i] <= st_exec_size;
          sq_zero[i] <= st_exec_zero;
        end
        if (cm_st_valid && sq_vld[i] && sq_sn[i] <= cm_st_seq) begin
          sq_cmt[i]   <= 1'b1;
          sq_canwb[i] <= 1'b1;
        end
        if (wb_fire && sq_wb == SIW'(i)) sq_done[i] <= 1'b1;
        if ((st_ret && sq_head == SIW'(i)) || (st_kill && st_last == SIW'(i))) begin
          sq_vld[i]   <= 1'b0;
          sq_cmt[i]   <= 1'b0;
          sq_canwb[i] <= 1'b0;
          sq_done[i]  <= 1'b0;
        end
        if (st_go && sq_tail == SIW'(i)) begin
          sq_vld[i]   <= 1'b1;
          sq_sn[i]    <= st_seq;
          sq_cmt[i]   <= 1'b0;
          sq_canwb[i] <= 1'b0;
          sq_done[i]  <= 1'b0;
        end
      end
      if (st_go) sq_tail <= s_inc(sq_tail);
      else if (st_kill) sq_tail <= st_last;
      if (st_ret) sq_head <= s_inc(sq_head);
      if (wb_fire) sq_wb <= s_inc(sq_wb);
      sq_cnt <= sq_cnt + SCW'(st_go) - SCW'(st_ret) - SCW'(st_kill);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tgt  <= '0;
    end else if (!busy) begin
      if (sq_req) begin
        busy <= 1'b1;
        tgt  <= sq_seq;
      end
    end else if (!ld_kill && !st_kill) begin
      busy <= 1'b0;
    end
  end

  p_lq_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lq_cnt <= LCW'(LQ_SLOTS - 1));

  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && !busy) |=> $stable(lq_tail));

  p_sq_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sq_cnt <= SCW'(SQ_SLOTS - 1));

  p_pend_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending <= sq_cnt);

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wb_valid && !mem_ready) |=> (st_wb_valid && $stable(sq_wb)));

  p_squash_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (lq_empty || lq_seq[lq_last] <= tgt));

  p_wb_inside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_wb != sq_tail) |-> sq_vld[sq_wb]);

endmodule

// File: tb/lsq_tracker_tb.sv
module lsq_tracker_tb;
  localparam int LQS = 6, SQS = 5, SW = 8, ZW = 5;
  localparam int LIW = 3, SIW = 3, LCW = 3, SCW = 3;

  logic clk = 0, rst_n = 0;
  logic ld_alloc = 0, st_alloc = 0, st_exec = 0, st_exec_zero = 0;
  logic cm_ld_valid = 0, cm_st_valid = 0, sq_req = 0, mem_ready = 0;
  logic [SW-1:0] ld_seq = 0, st_seq = 0, cm_ld_seq = 0, cm_st_seq = 0, sq_seq = 0;
  logic [SIW-1:0] st_exec_idx = 0;
  logic [ZW-1:0] st_exec_size = 0;
  logic [LIW-1:0] ld_alloc_idx;
  logic [SIW-1:0] st_alloc_idx, st_wb_idx;
  logic [LCW-1:0] lq_count, lq_free;
  logic [SCW-1:0] sq_count, sq_free, wb_pending;
  logic lq_full, sq_full, lq_empty, sq_empty, squash_busy, st_wb_valid, st_wb_zero;
  logic [ZW-1:0] st_wb_size;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsq_tracker #(.LQ_SLOTS(LQS), .SQ_SLOTS(SQS), .SEQ_W(SW), .SIZE_W(ZW)) u_dut (
    .clk, .rst_n, .ld_alloc, .ld_seq, .st_alloc, .st_seq, .st_exec, .st_exec_idx,
    .st_exec_size, .st_exec_zero, .cm_ld_valid, .cm_ld_seq, .cm_st_valid, .cm_st_seq,
    .sq_req, .sq_seq, .mem_ready, .ld_alloc_idx, .st_alloc_idx, .lq_count, .sq_count,
    .lq_free, .sq_free, .lq_full, .sq_full, .lq_empty, .sq_empty, .wb_pending,
    .squash_busy, .st_wb_valid, .st_wb_idx, .st_wb_size, .st_wb_zero);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 lq_empty", lq_empty, 1);
    chk("R1 sq_empty", sq_empty, 1);
    chk("R1 lq_free", lq_free, LQS - 1);
    chk("R1 sq_free", sq_free, SQS - 1);
    chk("R1 busy", squash_busy, 0);
    chk("R1 wb_valid", st_wb_valid, 0);
    chk("R1 wb_pending", wb_pending, 0);

    for (int i = 0; i < 7; i++) begin
      chk("R4 load idx", ld_alloc_idx, (i < LQS - 1) ? i : LQS - 1);
      ld_alloc = 1; ld_seq = SW'(10 + i);
      cyc(1);
      ld_alloc = 0;
      chk("R2 lq_count", lq_count, (i + 1 < LQS - 1) ? i + 1 : LQS - 1);
    end
    chk("R2 lq_full", lq_full, 1);
    chk("R2 lq_free", lq_free, 0);

    cm_ld_valid = 1; cm_ld_seq = 12;
    cyc(6);
    cm_ld_valid = 0;
    chk("R5 partial commit", lq_count, 2);

    for (int i = 0; i < 3; i++) begin
      chk("R4 load wrap idx", ld_alloc_idx, (5 + i) % LQS);
      ld_alloc = 1; ld_seq = SW'(15 + i);
      cyc(1);
      ld_alloc = 0;
    end
    chk("R2 refill", lq_count, 5);
    cm_ld_valid = 1; cm_ld_seq = 255;
    cyc(6);
    cm_ld_valid = 0;
    chk("R5 commit all", lq_empty, 1);

    for (int i = 0; i < 5; i++) begin
      chk("R4 store idx", st_alloc_idx, (i < SQS - 1) ? i : SQS - 1);
      st_alloc = 1; st_seq = SW'(20 + i);
      cyc(1);
      st_alloc = 0;
      chk("R3 sq_count", sq_count, (i + 1 < SQS - 1) ? i + 1 : SQS - 1);
    end
    chk("R3 sq_full", sq_full, 1);
    for (int i = 0; i < 4; i++) begin
      st_exec = 1; st_exec_idx = SIW'(i); st_exec_size = ZW'(i + 1); st_exec_zero = (i == 2);
      cyc(1);
    end
    st_exec = 0;
    chk("R7 no offer before commit", st_wb_valid, 0);

    cm_st_valid = 1; cm_st_seq = 21;
    cyc(1);
    cm_st_valid = 0;
    chk("R6 wb_pending", wb_pending, 2);
    chk("R7 wb_valid", st_wb_valid, 1);
    chk("R7 wb_idx", st_wb_idx, 0);
    chk("R7 wb_size", st_wb_size, 1);

    cyc(3);
    chk("R8 held valid", st_wb_valid, 1);
    chk("R8 held idx", st_wb_idx, 0);
    chk("R9 no free at commit", sq_count, 4);

    mem_ready = 1;
    cyc(1);
    mem_ready = 0;
    chk("R8 advanced idx", st_wb_idx, 1);
    chk("R8 next size", st_wb_size, 2);
    chk("R6 pending after accept", wb_pending, 1);
    chk("R9 count at accept", sq_count, 4);
    cyc(1);
    chk("R9 freed after accept", sq_count, 3);

    for (int i = 0; i < 3; i++) begin
      ld_alloc = 1; ld_seq = (i == 0) ? 8'd18 : SW'(29 + i);
      cyc(1);
    end
    ld_alloc = 0;
    chk("R2 loads for squash", lq_count, 3);

    sq_req = 1; sq_seq = 21;
    cyc(1);
    sq_req = 0;
    chk("R10 busy", squash_busy, 1);
    ld_alloc = 1; ld_seq = 40; st_alloc = 1; st_seq = 41;
    cyc(1);
    ld_alloc = 0; st_alloc = 0;
    for (int i = 0; i < 20 && squash_busy; i++) cyc(1);
    chk("R10 busy fell", squash_busy, 0);
    chk("R10 lq after squash", lq_count, 1);
    chk("R10 sq after squash", sq_count, 1);
    chk("R10 store tail", st_alloc_idx, 2);

    sq_req = 1; sq_seq = 5;
    cyc(1);
    sq_req = 0;
    for (int i = 0; i < 20 && squash_busy; i++) cyc(1);
    chk("R11 committed store kept", sq_count, 1);
    chk("R10 old load removed", lq_count, 0);
    chk("R11 offer kept", st_wb_valid, 1);
    chk("R11 offer idx", st_wb_idx, 1);

    mem_ready = 1;
    cyc(1);
    mem_ready = 0;
    chk("R8 nothing offered", st_wb_valid, 0);
    cyc(1);
    chk("R9 store queue empty", sq_empty, 1);

    for (int i = 0; i < 4; i++) begin
      chk("R4 store wrap idx", st_alloc_idx, (2 + i) % SQS);
      st_alloc = 1; st_seq = SW'(50 + i);
      cyc(1);
    end
    st_alloc = 0;
    for (int i = 0; i < 4; i++) begin
      st_exec = 1; st_exec_idx = SIW'((2 + i) % SQS); st_exec_size = 7;
      st_exec_zero = (((2 + i) % SQS) == 3);
      cyc(1);
    end
    st_exec = 0;
    cm_st_valid = 1; cm_st_seq = 255;
    cyc(1);
    cm_st_valid = 0;
    chk("R6 all pending", wb_pending, 4);
    mem_ready = 1;
    for (int k = 0; k < 4; k++) begin
      chk("R8 wrap order", st_wb_idx, (2 + k) % SQS);
      chk("R7 zero flag", st_wb_zero, (((2 + k) % SQS) == 3) ? 1 : 0);
      cyc(1);
    end
    mem_ready = 0;
    cyc(2);
    chk("R9 drained", sq_empty, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule